// File: doc/BRIEF.md
# Two-Stage Split-Precision Execution Unit

This block is a two-stage pipelined integer execution unit. Each cycle it may accept a work parcel made of a 4-bit command and two 32-bit operands. Arithmetic and logical commands are split by width. The first stage produces the low half of the result and registers the carry or borrow out of that half. The second stage then produces the high half using that carry. Shifts and rotates pass through the first stage untouched and are carried out entirely in the second stage.

The result appears on an output data field together with a valid flag. Two lock inputs are ORed into a single interlock, and while it is high both stages keep their contents. A bus-request input takes the output field away from the unit. While that request is high the unit drives zeros with the flag low, and it holds any finished result until the request drops.

Top module: `split_alu`

## Requirements
- R1: Command code 0 adds the operands modulo 2^32. A parcel accepted at one clock edge shows its result on the output after the next edge.
- R2: Command code 1 computes opa minus opb in 32-bit two's complement, so 0 minus 31 gives 0xFFFFFFE1.
- R3: The carry or borrow out of the low half of an add or subtract reaches the high half. For example, 0x0000FFFF plus 1 gives 0x00010000, and 0x00010000 minus 1 gives 0x0000FFFF.
- R4: Command codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands over all 32 bits.
- R5: Command code 5 shifts opa left and code 6 shifts it right logically. The shift amount is opb[4:0], and the upper bits of opb have no effect.
- R6: Command code 7 rotates opa right by opb[4:0] bit positions.
- R7: Command codes 8 to 15 deliver opa unchanged as the result.
- R8: While lock_a or lock_b is high, out_valid and out_data do not change unless io_req changes, and an in_valid parcel offered in that cycle is not accepted.
- R9: While io_req is high, out_valid and out_data are zero. A result waiting in the second stage is kept and appears once io_req is low.
- R10: During and just after reset, out_valid and out_data are zero.
- R11: Every accepted parcel yields exactly one result, in order of acceptance. In cycles with no result, out_valid is low and out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A parcel is offered |
| in_cmd | input | 4 | Command code |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Second operand or shift amount |
| lock_a | input | 1 | First interlock source |
| lock_b | input | 1 | Second interlock source |
| io_req | input | 1 | Bus request from another unit; blocks the output |
| out_valid | output | 1 | out_data carries a result this cycle |
| out_data | output | 32 | Result field |

## Verification
The assertions assume that the lock and bus-request inputs change only between clock edges and that reset is applied from the first edge. The stability check under interlock is therefore meaningful only when io_req stays still across the same cycles. The stimulus changes every input on the falling edge. It never offers a parcel while io_req is high, so whether a parcel is accepted depends only on the lock inputs, which the bench can see. Sweeps cover every command code against a grid of edge-value operands and every shift amount. They run with lock and bus-request pulses woven in.

// File: rtl/split_alu.sv
module split_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   in_cmd,
  input  logic [W-1:0] in_opa,
  input  logic [W-1:0] in_opb,
  input  logic         lock_a,
  input  logic         lock_b,
  input  logic         io_req,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int H  = W / 2;
  localparam int SW = $clog2(W);

  localparam logic [3:0] C_ADD = 4'd0;
  localparam logic [3:0] C_SUB = 4'd1;
  localparam logic [3:0] C_AND = 4'd2;
  localparam logic [3:0] C_OR  = 4'd3;
  localparam logic [3:0] C_XOR = 4'd4;
  localparam logic [3:0] C_SHL = 4'd5;
  localparam logic [3:0] C_SHR = 4'd6;
  localparam logic [3:0] C_ROR = 4'd7;

  logic         s1_v, s1_c;
  logic [3:0]   s1_cmd;
  logic [H-1:0] s1_lo, s1_ahi, s1_bhi;
  logic [SW-1:0] s1_amt;
  logic         s2_v;
  logic [W-1:0] s2_data;

  wire lock = lock_a | lock_b;
  wire adv  = ~lock & ~(s2_v & io_req);

  wire [H-1:0] a_lo = in_opa[H-1:0];
  wire [H-1:0] b_lo = in_opb[H-1:0];
  wire         sub1 = (in_cmd == C_SUB);
  wire [H:0]   lo_sum = {1'b0, a_lo} + {1'b0, sub1 ? ~b_lo : b_lo} + {{H{1'b0}}, sub1};

  logic [H-1:0] lo_nxt;
  logic         c_nxt;
  always_comb begin
    c_nxt = 1'b0;
    case (in_cmd)
      C_ADD, C_SUB: begin lo_nxt = lo_sum[H-1:0]; c_nxt = lo_sum[H]; end
      C_AND:        lo_nxt = a_lo & b_lo;
      C_OR:         lo_nxt = a_lo | b_lo;
      C_XOR:        lo_nxt = a_lo ^ b_lo;
      default:      lo_nxt = a_lo;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_c   <= 1'b0;
      s1_cmd <= '0;
      s1_lo  <= '0;
      s1_ahi <= '0;
      s1_bhi <= '0;
      s1_amt <= '0;
    end else if (adv) begin
      s1_v   <= in_valid;
      s1_c   <= c_nxt;
      s1_cmd <= in_cmd;
      s1_lo  <= lo_nxt;
      s1_ahi <= in_opa[W-1:H];
      s1_bhi <= in_opb[W-1:H];
      s1_amt <= in_opb[SW-1:0];
    end
  end

  wire [W-1:0]   opa_full = {s1_ahi, s1_lo};
  wire [2*W-1:0] dbl      = {opa_full, opa_full} >> s1_amt;
  wire [H-1:0]   hi_sum   = s1_ahi + ((s1_cmd == C_SUB) ? ~s1_bhi : s1_bhi) + {{(H-1){1'b0}}, s1_c};

  logic [W-1:0] r2;
  always_comb begin
    case (s1_cmd)
      C_ADD, C_SUB: r2 = {hi_sum, s1_lo};
      C_AND:        r2 = {s1_ahi & s1_bhi, s1_lo};
      C_OR:         r2 = {s1_ahi | s1_bhi, s1_lo};
      C_XOR:        r2 = {s1_ahi ^ s1_bhi, s1_lo};
      C_SHL:        r2 = opa_full << s1_amt;
      C_SHR:        r2 = opa_full >> s1_amt;
      C_ROR:        r2 = dbl[W-1:0];
      default:      r2 = opa_full;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_data <= '0;
    end else if (adv) begin
      s2_v    <= s1_v;
      s2_data <= s1_v ? r2 : '0;
    end
  end

  assign out_valid = s2_v & ~io_req;
  assign out_data  = out_valid ? s2_data : '0;
endmodule

module split_alu_props #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lock_a,
  input logic         lock_b,
  input logic         io_req,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));

  assert_bus_yield_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (!out_valid && out_data == '0));

  assert_result_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid) && io_req) |=> (io_req || out_valid));

  assert_lock_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_a || lock_b) && !io_req) |=> (io_req || ($stable(out_valid) && $stable(out_data))));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
endmodule

bind split_alu split_alu_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .lock_a(lock_a), .lock_b(lock_b),
  .io_req(io_req), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/split_alu_test.sv
module split_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_cmd = '0;
  logic [31:0] in_opa = '0, in_opb = '0;
  logic        lock_a = 1'b0, lock_b = 1'b0, io_req = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  split_alu uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] expq [0:8191];
  int wr = 0, rd = 0;
  bit prev_hold = 0;
  logic prev_v;
  logic [31:0] prev_d;
  int nstep = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    int n;
    n = int'(b[4:0]);
    case (c)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return a << n;
      4'd6: return a >> n;
      4'd7: return (n == 0) ? a : ((a >> n) | (a << (32 - n)));
      default: return a;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  string tagq [0:8191];

  task automatic step(input bit v, input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                      input bit la, input bit lb, input bit ir);
    @(negedge clk);
    in_valid = v; in_cmd = c; in_opa = a; in_opb = b;
    lock_a = la; lock_b = lb; io_req = ir;
    #1;
    if (ir) chk(!out_valid && out_data == 0, "R9", out_data, 32'h0);
    if (prev_hold && !ir) chk(out_valid == prev_v && out_data == prev_d, "R8", out_data, prev_d);
    if (out_valid && !(la || lb)) begin
      if (rd == wr) chk(1'b0, "R11", out_data, 32'h0);
      else begin
        chk(out_data == expq[rd[12:0]], tagq[rd[12:0]], out_data, expq[rd[12:0]]);
        rd++;
      end
    end
    if (!out_valid) chk(out_data == 0, "R11", out_data, 32'h0);
    if (v && !la && !lb && !ir) begin
      expq[wr[12:0]] = model(c, a, b);
      tagq[wr[12:0]] = tag(c);
      wr++;
    end
    prev_hold = (la || lb) && !ir;
    prev_v = out_valid;
    prev_d = out_data;
  endtask

  task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    nstep++;
    if (nstep % 7 == 0) step(1'b1, c, a, b, 1'b1, 1'b0, 1'b0);
    if (nstep % 11 == 0) step(1'b0, c, a, b, 1'b0, 1'b1, 1'b0);
    if (nstep % 13 == 0) begin
      step(1'b0, 4'd0, 0, 0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 4'd0, 0, 0, 1'b0, 1'b0, 1'b1);
    end
    if (nstep % 17 == 0) step(1'b0, 4'd0, 0, 0, 1'b1, 1'b0, 1'b1);
    step(1'b1, c, a, b, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_001F;
      3: return 32'h0000_FFFF;
      4: return 32'h0001_0000;
      5: return 32'h7FFF_FFFF;
      6: return 32'h8000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && out_data == 0, "R10", out_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(!out_valid && out_data == 0, "R10", out_data, 32'h0);

    // R2 and R3 corner cases
    issue(4'd1, 32'd0, 32'd31);
    issue(4'd0, 32'h0000_FFFF, 32'd1);
    issue(4'd1, 32'h0001_0000, 32'd1);
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          issue(c[3:0], pat(i), pat(j) ^ (32'h0123_4567 * j[31:0]));
    // R5 R6 amounts with upper opb bits set
    for (int c = 5; c < 8; c++)
      for (int n = 0; n < 32; n++)
        issue(c[3:0], 32'h8C31_F0A5, 32'hABCD_EF00 | n[31:0]);
    // R8 parcel offered under lock only
    step(1'b1, 4'd0, 32'd5, 32'd6, 1'b0, 1'b1, 1'b0);
    step(1'b1, 4'd0, 32'd7, 32'd8, 1'b1, 1'b1, 1'b0);
    // R9 result held across long request
    issue(4'd4, 32'hDEAD_BEEF, 32'h0F0F_0F0F);
    for (int k = 0; k < 6; k++) step(1'b0, 4'd0, 0, 0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b0, 4'd0, 0, 0, 1'b0, 1'b0, 1'b0);
    chk(rd == wr, "R11", rd, wr);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule